// File: doc/BRIEF.md
# Shared-Bus Steal Arbiter

This block drives the two bus-grant lines that a processor sees when it shares memory with a video fetch engine. The first is the bus-available line (BA), which gives early warning. The second is the address-enable line (AEC), which hands the second clock phase over. For each cycle of a 63-cycle raster line, the block works out whether the video side takes that cycle's second phase. It takes it for character fetches on a bad line, and for each pair of sprite fetches belonging to a sprite that is active on the next line.

BA must warn the processor ahead of time. It drops three cycles before the first taken phase. In the gap that follows, the processor can still finish its pending writes, and it stops at its next read. AEC drops only on the cycles that are really taken.

The block is given three inputs: the current cycle number (1 to 63), the bad-line flag and the eight-bit next-line sprite mask. It registers BA, AEC and a two-bit status code. All three outputs take effect on the clock edge that samples the cycle number.

Top module: `bus_steal_arbiter`

## Requirements
- R1: While reset is held, BA and AEC are high and the status code is 0.
- R2: The outputs are registered: the values for the cycle number, bad flag and sprite mask sampled at a clock edge appear just after that edge and hold for one clock.
- R3: AEC is low exactly on cycles whose second phase is taken. A bad line takes cycles 15 through 54.
- R4: Sprite s (bit s of the mask, 0 to 7) takes cycles 58+2s and 59+2s, counted modulo 63 into the range 1..63. Sprites 3 to 7 therefore take cycles 1 to 10. With only sprites 1 and 2 set, BA falls at cycle 57 and AEC at cycle 60.
- R5: BA is low on cycle c exactly when at least one of the cycles c, c+1, c+2, c+3 is taken. This lookahead wraps from cycle 63 to cycle 1, so free slots between sprites give BA back only when the gap is long enough.
- R6: On a bad line with no sprites, BA is high for cycles 1 to 11 and low for cycles 12 to 54. AEC is high for cycles 12 to 14 and low for cycles 15 to 54. Both are high from cycle 55 on.
- R7: With the bad flag clear and the mask zero, BA and AEC stay high on every cycle.
- R8: The status code is 0 when BA is high. It is 1 when BA is low and AEC is high, so writes may still complete. It is 2 when AEC is low and the bus is gone. It is never 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc | input | 6 | Current cycle number within the line, 1..63 |
| bad_line | input | 1 | Current line needs character fetches |
| spr_next | input | 8 | Sprites active on the next line, bit s for sprite s |
| ba | output | 1 | Bus available; low warns that a steal is near |
| aec | output | 1 | Address enable; low while the phase is taken |
| bus_state | output | 2 | 0 running, 1 request pending, 2 bus taken |

## Verification
The lines are swept with these patterns:
- An idle line, which shows that nothing is stolen without demand.
- A bad line alone, which sets the 12/15/54 edges.
- A bad line together with sprites 0 to 2, where the sprite lead-in runs straight on from the bad-line steal.
- Sprites 1 and 2 only, which shift the BA and AEC falls to 57 and 60.
- Sprites 1, 3 and 7, whose gaps open and close BA across the line wrap.
- All sprites together, and a lone sprite 7.

A behavioural model builds the set of taken cycles for each pattern and is compared on every clock. Spot checks pin the documented edge cycles.

// File: rtl/bus_steal_arbiter.sv
module bus_steal_arbiter #(
  parameter int LINE_CYCLES = 63,
  parameter int CYC_W       = 6,
  parameter int NUM_SPR     = 8,
  parameter int BAD_FIRST   = 15,
  parameter int BAD_LAST    = 54,
  parameter int SPR_FIRST   = 58,
  parameter int LEAD        = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CYC_W-1:0]   cyc,
  input  logic               bad_line,
  input  logic [NUM_SPR-1:0] spr_next,
  output logic               ba,
  output logic               aec,
  output logic [1:0]         bus_state
);

  localparam logic [1:0] ST_RUN  = 2'd0;
  localparam logic [1:0] ST_PEND = 2'd1;
  localparam logic [1:0] ST_TAKE = 2'd2;

  function automatic int wrap_add(int c, int k);
    return ((c - 1 + k) % LINE_CYCLES) + 1;
  endfunction

  function automatic logic taken(int c, logic bad, logic [NUM_SPR-1:0] m);
    logic hit;
    int   st;
    hit = bad && (c >= BAD_FIRST) && (c <= BAD_LAST);
    for (int s = 0; s < NUM_SPR; s++) begin
      st = wrap_add(SPR_FIRST, 2 * s);
      if (m[s] && ((c == st) || (c == wrap_add(st, 1)))) hit = 1'b1;
    end
    return hit;
  endfunction

  logic steal_now;
  logic demand;
  logic ba_q, aec_q;
  logic [1:0] st_q;

  always_comb begin
    steal_now = taken(int'(cyc), bad_line, spr_next);
    demand    = 1'b0;
    for (int k = 0; k <= LEAD; k++)
      demand = demand | taken(wrap_add(int'(cyc), k), bad_line, spr_next);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_q  <= 1'b1;
      aec_q <= 1'b1;
      st_q  <= ST_RUN;
    end else begin
      ba_q  <= !demand;
      aec_q <= !steal_now;
      st_q  <= steal_now ? ST_TAKE : (demand ? ST_PEND : ST_RUN);
    end
  end

  assign ba        = ba_q;
  assign aec       = aec_q;
  assign bus_state = st_q;

  p_reset_high_r1: assert property (@(posedge clk)
    !rst_n |=> (ba && aec && bus_state == ST_RUN));

  p_aec_under_ba_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !aec |-> !ba);

  p_bad_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_line && cyc >= CYC_W'(BAD_FIRST) && cyc <= CYC_W'(BAD_LAST)) |=> !aec);

  p_early_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_next == '0 && cyc >= CYC_W'(1) && cyc <= CYC_W'(BAD_FIRST - LEAD - 1)) |=> ba);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad_line && spr_next == '0) |=> (ba && aec));

  p_state_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state != 2'd3) && ((bus_state == ST_TAKE) == !aec) && ((bus_state == ST_RUN) == ba));

endmodule

// File: tb/tb_bus_steal_arbiter.sv
`timescale 1ns/1ps
module tb_bus_steal_arbiter;
  logic clk = 1'b0;
  logic rst_n;
  logic [5:0] cyc;
  logic bad_line;
  logic [7:0] spr_next;
  logic ba, aec;
  logic [1:0] bus_state;

  int checks = 0;
  int errors = 0;
  bit obs_ba [1:63];
  bit obs_aec[1:63];

  always #2 clk = ~clk;

  bus_steal_arbiter dut (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .bad_line(bad_line),
    .spr_next(spr_next), .ba(ba), .aec(aec), .bus_state(bus_state)
  );

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int nxt(int c, int k);
    return ((c - 1 + k) % 63) + 1;
  endfunction

  task automatic run_pattern(bit bad, bit [7:0] m);
    int q[$];
    bit st, dem;
    int ex_state;
    q = {};
    if (bad) for (int c = 15; c <= 54; c++) q.push_back(c);
    for (int s = 0; s < 8; s++)
      if (m[s]) begin
        q.push_back(nxt(58, 2 * s));
        q.push_back(nxt(58, 2 * s + 1));
      end
    bad_line = bad;
    spr_next = m;
    for (int line = 0; line < 2; line++)
      for (int k = 1; k <= 63; k++) begin
        cyc = 6'(k);
        @(negedge clk);
        st  = 0;
        dem = 0;
        foreach (q[i]) begin
          if (q[i] == k) st = 1;
          for (int d = 0; d <= 3; d++) if (q[i] == nxt(k, d)) dem = 1;
        end
        ex_state = st ? 2 : (dem ? 1 : 0);
        chk("R3", aec, !st, $sformatf("aec cyc %0d mask %02h bad %0d", k, m, bad));
        chk("R5", ba, !dem, $sformatf("ba cyc %0d mask %02h bad %0d", k, m, bad));
        chk("R8", bus_state, ex_state, $sformatf("state cyc %0d mask %02h", k, m));
        obs_ba[k]  = ba;
        obs_aec[k] = aec;
      end
  endtask

  initial begin
    rst_n = 1'b0; cyc = 6'd1; bad_line = 1'b1; spr_next = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R1", ba, 1, "ba in reset");
    chk("R1", aec, 1, "aec in reset");
    chk("R1", bus_state, 0, "state in reset");
    rst_n = 1'b1;

    run_pattern(1'b0, 8'h00);
    for (int k = 1; k <= 63; k++) chk("R7", obs_ba[k] & obs_aec[k], 1, $sformatf("idle cyc %0d", k));

    run_pattern(1'b1, 8'h00);
    chk("R6", obs_ba[11], 1, "ba cyc 11");
    chk("R6", obs_ba[12], 0, "ba cyc 12");
    chk("R6", obs_aec[14], 1, "aec cyc 14");
    chk("R2", obs_aec[15], 0, "aec cyc 15 right after its edge");
    chk("R6", obs_aec[54], 0, "aec cyc 54");
    chk("R6", obs_ba[55] & obs_aec[55], 1, "both cyc 55");

    run_pattern(1'b1, 8'h07);
    chk("R4", obs_ba[55], 0, "ba cyc 55 sprites 0-2");
    chk("R4", obs_aec[57], 1, "aec cyc 57 sprites 0-2");
    chk("R4", obs_aec[58], 0, "aec cyc 58 sprites 0-2");

    run_pattern(1'b0, 8'h06);
    chk("R4", obs_ba[56], 1, "ba cyc 56 sprites 1,2");
    chk("R4", obs_ba[57], 0, "ba cyc 57 sprites 1,2");
    chk("R4", obs_aec[59], 1, "aec cyc 59 sprites 1,2");
    chk("R4", obs_aec[60], 0, "aec cyc 60 sprites 1,2");

    run_pattern(1'b0, 8'h8A);
    chk("R4", obs_aec[1], 0, "aec cyc 1 sprite 3");
    chk("R5", obs_ba[3], 1, "ba cyc 3 gap");
    chk("R5", obs_ba[5], 1, "ba cyc 5 gap");
    chk("R5", obs_ba[6], 0, "ba cyc 6 before sprite 7");
    chk("R5", obs_aec[8], 1, "aec cyc 8");
    chk("R4", obs_aec[9], 0, "aec cyc 9 sprite 7");
    chk("R5", obs_ba[62], 0, "ba cyc 62 wrap lookahead");

    run_pattern(1'b1, 8'hFF);
    run_pattern(1'b0, 8'h80);
    chk("R5", obs_ba[5], 1, "ba cyc 5 lone sprite 7");
    chk("R5", obs_ba[6], 0, "ba cyc 6 lone sprite 7");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule